// File: doc/BRIEF.md
# Oscillator Auto-Trim Controller

This block keeps an on-chip fast RC oscillator on frequency by adjusting its trim code in a closed loop. The block runs on the oscillator's own clock. It measures how many of these clock cycles fit into a window of several periods of a 32.768 kHz reference clock, and it compares that count with the count the 48 MHz target should give. After each measurement it moves the trim code one step toward the target. It reports lock when the count falls inside a tolerance band.

The loop starts when the 2-bit frequency select holds 01. The loop gives up when a programmable number of trim updates pass without lock. It also flags a count that is grossly off target, and it can stop on that condition. When the loop stops by itself, the hardware clears the frequency select back to 00. The failure flag and the clock-error flag each raise the interrupt line only while their own enable is set. Writing 1 to the matching clear input clears a flag.

Top module: `osc_autotrim`

## Requirements
- R1: After reset, trim holds the mid code 2^(TRIM_W-1), freq_sel is 00, and locked, fail_flag, err_flag and irq are all 0.
- R2: The loop runs only while freq_sel is 01. The values 00, 10 and 11 leave trim unchanged and locked at 0.
- R3: The expected count is CYC_PER_REF × W, where W is the window length in reference periods: loop_sel 0, 1, 2 and 3 give 4, 8, 16 and 32. The window opens on the first reference rising edge after the start or after the previous trim update, so the reference period that contains an update is never measured.
- R4: Each window gives at most one trim step. A count above expected + tolerance lowers trim by 1. A count below expected − tolerance raises trim by 1.
- R5: Trim saturates: it never goes below 0 and never goes above 2^TRIM_W − 1.
- R6: A count within ±tolerance of expected sets locked and clears the update counter. The tolerance is the bound input when bound_en is 1, and 0 otherwise.
- R7: The retry limit is RETRY_BASE × 2^retry_sel updates. When the update counter reaches this limit without lock, fail_flag sets, freq_sel becomes 00, locked clears, and trim stops changing.
- R8: When |count − expected| > expected/8, err_flag sets. If stop_on_err is 1, freq_sel becomes 00 and trim does not step. If stop_on_err is 0, the loop keeps stepping.
- R9: A one-cycle pulse on clr_fail or clr_err clears the matching flag.
- R10: irq is 1 exactly when (fail_flag and fail_ie) or (err_flag and err_ie).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being trimmed |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | 32.768 kHz reference, asynchronous to clk |
| cfg_wr | input | 1 | Write strobe for cfg_fsel |
| cfg_fsel | input | 2 | Frequency select value to write (01 = run) |
| loop_sel | input | 2 | Window length select |
| retry_sel | input | 2 | Retry limit select |
| stop_on_err | input | 1 | Stop the loop on gross clock error |
| bound_en | input | 1 | Use bound as the lock tolerance |
| bound | input | 5 | Lock tolerance in counts |
| fail_ie | input | 1 | Interrupt enable for the trim failure flag |
| err_ie | input | 1 | Interrupt enable for the clock-error flag |
| clr_fail | input | 1 | Write-1 clear of fail_flag |
| clr_err | input | 1 | Write-1 clear of err_flag |
| freq_sel | output | 2 | Current frequency select |
| trim | output | TRIM_W | Trim code for the oscillator |
| locked | output | 1 | Frequency within tolerance |
| fail_flag | output | 1 | Retry limit reached without lock |
| err_flag | output | 1 | Gross frequency error seen |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that configuration inputs stay steady during a run. They also assume that cfg_wr and the clear pulses do not land on the cycle in which the hardware itself clears freq_sel or sets a flag. Finally, they assume that the reference period is many clock cycles long, so two reference edges never fall inside one evaluation. The bench keeps to these assumptions. It changes settings only while the loop is idle, and it sends clears only after the loop has stopped. Its oscillator model keeps every reference period above 20 clock cycles.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_MEAS,
    ST_EVAL
  } trim_state_e;

  localparam logic [1:0] FSEL_RUN  = 2'b01;
  localparam logic [1:0] FSEL_OFF  = 2'b00;
  localparam int         WIN_MAX   = 32;
  localparam int         PER_W     = 5;
endpackage

// File: rtl/osc_trim_ref_sync.sv
module osc_trim_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic ref_rise
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], ref_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign ref_rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/osc_trim_window.sv
module osc_trim_window
  import osc_trim_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open,
  input  logic             active,
  input  logic             ref_rise,
  input  logic [PER_W-1:0] periods_m1,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q, per_d;

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    if (open) begin
      cnt_d = '0;
      per_d = '0;
    end else if (active) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      if (ref_rise)         per_d = per_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  assign cnt  = cnt_q;
  assign done = active & ref_rise & (per_q == periods_m1);

  // R3: the window count advances by one each cycle it is open
  a_r3_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !open && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/osc_trim_judge.sv
module osc_trim_judge #(
  parameter int CNT_W = 17
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] expected,
  input  logic [4:0]       tol,
  output logic             too_fast,
  output logic             too_slow,
  output logic             gross
);
  logic [CNT_W:0]   cnt_x, exp_x, tol_x;
  logic [CNT_W-1:0] diff;

  always_comb begin
    cnt_x    = {1'b0, cnt};
    exp_x    = {1'b0, expected};
    tol_x    = (CNT_W+1)'(tol);
    too_fast = cnt_x > (exp_x + tol_x);
    too_slow = (cnt_x + tol_x) < exp_x;
    diff     = (cnt >= expected) ? (cnt - expected) : (expected - cnt);
    gross    = diff > (expected >> 3);
  end
endmodule

// File: rtl/osc_autotrim.sv
module osc_autotrim
  import osc_trim_pkg::*;
#(
  parameter int TRIM_W      = 8,
  parameter int CYC_PER_REF = 1465,
  parameter int RETRY_BASE  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_fsel,
  input  logic [1:0]        loop_sel,
  input  logic [1:0]        retry_sel,
  input  logic              stop_on_err,
  input  logic              bound_en,
  input  logic [4:0]        bound,
  input  logic              fail_ie,
  input  logic              err_ie,
  input  logic              clr_fail,
  input  logic              clr_err,
  output logic [1:0]        freq_sel,
  output logic [TRIM_W-1:0] trim,
  output logic              locked,
  output logic              fail_flag,
  output logic              err_flag,
  output logic              irq
);
  localparam int CNT_W = $clog2(CYC_PER_REF * WIN_MAX * 2 + 1);
  localparam int RTY_W = $clog2(RETRY_BASE * 8 + 1);
  localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};
  localparam logic [TRIM_W-1:0] TRIM_MID = TRIM_W'(1) << (TRIM_W - 1);

  trim_state_e       state_q, state_d;
  logic [1:0]        fsel_q, fsel_d;
  logic [TRIM_W-1:0] trim_q, trim_d;
  logic              locked_q, locked_d;
  logic              fail_q, fail_d, err_q, err_d;
  logic [RTY_W-1:0]  retry_q, retry_d, retry_inc, retry_lim;

  logic             ref_rise, win_open, win_active, win_done;
  logic [CNT_W-1:0] win_cnt, exp_cnt;
  logic [PER_W-1:0] periods_m1;
  logic [4:0]       tol;
  logic             too_fast, too_slow, gross, run, fail_set, err_set;

  assign exp_cnt    = CNT_W'(CYC_PER_REF) << ({1'b0, loop_sel} + 3'd2);
  assign periods_m1 = PER_W'((6'd4 << loop_sel) - 6'd1);
  assign tol        = bound_en ? bound : 5'd0;
  assign retry_lim  = RTY_W'(RETRY_BASE) << retry_sel;
  assign retry_inc  = retry_q + 1'b1;
  assign run        = (fsel_q == FSEL_RUN);
  assign win_open   = (state_q == ST_SETTLE) && ref_rise;
  assign win_active = (state_q == ST_MEAS);

  osc_trim_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_clk), .ref_rise(ref_rise)
  );

  osc_trim_window #(.CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .open(win_open), .active(win_active),
    .ref_rise(ref_rise), .periods_m1(periods_m1), .cnt(win_cnt), .done(win_done)
  );

  osc_trim_judge #(.CNT_W(CNT_W)) u_judge (
    .cnt(win_cnt), .expected(exp_cnt), .tol(tol),
    .too_fast(too_fast), .too_slow(too_slow), .gross(gross)
  );

  always_comb begin
    state_d  = state_q;
    fsel_d   = cfg_wr ? cfg_fsel : fsel_q;
    trim_d   = trim_q;
    locked_d = locked_q;
    retry_d  = retry_q;
    fail_set = 1'b0;
    err_set  = 1'b0;
    if (!run) begin
      state_d  = ST_IDLE;
      locked_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_SETTLE;
          retry_d = '0;
        end
        ST_SETTLE: if (ref_rise) state_d = ST_MEAS;
        ST_MEAS:   if (win_done) state_d = ST_EVAL;
        ST_EVAL: begin
          err_set = gross;
          state_d = ST_SETTLE;
          if (gross && stop_on_err) begin
            fsel_d   = FSEL_OFF;
            locked_d = 1'b0;
            state_d  = ST_IDLE;
          end else if (!too_fast && !too_slow) begin
            locked_d = 1'b1;
            retry_d  = '0;
          end else begin
            locked_d = 1'b0;
            if (too_fast && trim_q != '0)       trim_d = trim_q - 1'b1;
            if (too_slow && trim_q != TRIM_MAX) trim_d = trim_q + 1'b1;
            retry_d = retry_inc;
            if (retry_inc >= retry_lim) begin
              fail_set = 1'b1;
              fsel_d   = FSEL_OFF;
              state_d  = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
    fail_d = (fail_q & ~clr_fail) | fail_set;
    err_d  = (err_q & ~clr_err) | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      fsel_q   <= FSEL_OFF;
      trim_q   <= TRIM_MID;
      locked_q <= 1'b0;
      fail_q   <= 1'b0;
      err_q    <= 1'b0;
      retry_q  <= '0;
    end else begin
      state_q  <= state_d;
      fsel_q   <= fsel_d;
      trim_q   <= trim_d;
      locked_q <= locked_d;
      fail_q   <= fail_d;
      err_q    <= err_d;
      retry_q  <= retry_d;
    end
  end

  assign freq_sel  = fsel_q;
  assign trim      = trim_q;
  assign locked    = locked_q;
  assign fail_flag = fail_q;
  assign err_flag  = err_q;
  assign irq       = (fail_q & fail_ie) | (err_q & err_ie);

  // R2: trim holds whenever the loop was not selected to run
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fsel_q) != FSEL_RUN) |-> $stable(trim_q));
  // R4/R5: single unit steps, no wrap-around
  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_q != $past(trim_q)) |->
      (({1'b0, trim_q} == {1'b0, $past(trim_q)} + (TRIM_W+1)'(1)) ||
       ({1'b0, $past(trim_q)} == {1'b0, trim_q} + (TRIM_W+1)'(1))));
  // R6: gaining lock leaves the update counter empty
  a_r6_lock_clears_retry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> (retry_q == '0));
  // R7: failure always disables the loop
  a_r7_fail_disables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> (fsel_q == FSEL_OFF));
  // R8: stop-on-error disables the loop when the error flag rises
  a_r8_err_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err_q) && $past(stop_on_err)) |-> (fsel_q == FSEL_OFF));
  // R9: a clear outside evaluation leaves the flag low
  a_r9_fail_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fail && state_q != ST_EVAL) |=> !fail_q);
endmodule

// File: tb/osc_autotrim_tb.sv
module osc_autotrim_tb;
  localparam int TW  = 6;
  localparam int CPR = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_fsel = 2'b00;
  logic [1:0] loop_sel = 2'b00;
  logic [1:0] retry_sel = 2'b00;
  logic stop_on_err = 1'b0;
  logic bound_en = 1'b0;
  logic [4:0] bound = 5'd0;
  logic fail_ie = 1'b0;
  logic err_ie = 1'b0;
  logic clr_fail = 1'b0;
  logic clr_err = 1'b0;
  logic [1:0] freq_sel;
  logic [TW-1:0] trim;
  logic locked, fail_flag, err_flag, irq;

  int n_chk = 0;
  int n_bad = 0;
  int ok_trim = 32;
  bit finished = 0;

  osc_autotrim #(.TRIM_W(TW), .CYC_PER_REF(CPR), .RETRY_BASE(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .cfg_wr(cfg_wr), .cfg_fsel(cfg_fsel),
    .loop_sel(loop_sel), .retry_sel(retry_sel), .stop_on_err(stop_on_err),
    .bound_en(bound_en), .bound(bound), .fail_ie(fail_ie), .err_ie(err_ie),
    .clr_fail(clr_fail), .clr_err(clr_err), .freq_sel(freq_sel), .trim(trim),
    .locked(locked), .fail_flag(fail_flag), .err_flag(err_flag), .irq(irq)
  );

  always #5 clk = ~clk;

  // Oscillator model: a higher trim means more clk cycles per reference period
  initial begin
    int rcnt;
    int per;
    rcnt = 0;
    per = CPR;
    forever begin
      @(negedge clk);
      if (rcnt == 0) begin
        ref_clk = 1'b1;
        per = CPR + (int'(trim) - ok_trim);
        rcnt = per - 1;
      end else begin
        rcnt = rcnt - 1;
        if (rcnt == per / 2) ref_clk = 1'b0;
      end
    end
  end

  task automatic check(input bit good, input string tag, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_fsel(input logic [1:0] v);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_fsel = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_clear(input bit f, input bit e);
    @(negedge clk);
    clr_fail = f;
    clr_err = e;
    @(negedge clk);
    clr_fail = 1'b0;
    clr_err = 1'b0;
    @(negedge clk);
  endtask

  function automatic int lock_point(input int s, input int ok, input int n, input int tol);
    int t;
    t = s;
    while (t > ok && (t - ok) * n > tol) t--;
    while (t < ok && (ok - t) * n > tol) t++;
    return t;
  endfunction

  // {loop_sel, bound_en, bound, oscillator's ideal trim}
  localparam int VEC[6][4] = '{
    '{0, 0, 0, 36},
    '{1, 0, 0, 30},
    '{0, 1, 9, 33},
    '{2, 1, 20, 27},
    '{3, 0, 0, 29},
    '{1, 1, 31, 29}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cur;
    int exp_t;
    int guard;
    do_reset();
    // R1 reset state
    check(trim == 6'd32, "R1 trim", int'(trim), 32);
    check(freq_sel == 2'b00 && !locked, "R1 fsel/lock", int'(freq_sel), 0);
    check(!fail_flag && !err_flag && !irq, "R1 flags", int'({fail_flag, err_flag, irq}), 0);

    // R2 reserved select value: no trimming
    ok_trim = 40;
    write_fsel(2'b10);
    repeat (2000) @(negedge clk);
    check(trim == 6'd32 && !locked, "R2 reserved select", int'(trim), 32);
    write_fsel(2'b00);

    // R3/R4/R6 table walk
    cur = 32;
    for (int i = 0; i < 6; i++) begin
      loop_sel = 2'(VEC[i][0]);
      bound_en = VEC[i][1][0];
      bound = 5'(VEC[i][2]);
      ok_trim = VEC[i][3];
      exp_t = lock_point(cur, VEC[i][3], 4 << VEC[i][0], VEC[i][1] != 0 ? VEC[i][2] : 0);
      write_fsel(2'b01);
      guard = 0;
      while (!locked && guard < 40000) begin
        @(negedge clk);
        guard++;
      end
      check(locked == 1'b1, "R6 lock reached", int'(locked), 1);
      check(int'(trim) == exp_t, "R4 lock trim", int'(trim), exp_t);
      cur = int'(trim);
      write_fsel(2'b00);
      @(negedge clk);
      check(!locked, "R2 stop clears lock", int'(locked), 0);
    end

    // R5 high saturation, R7 failure, R8 continue without stop
    retry_sel = 2'b00;
    stop_on_err = 1'b0;
    loop_sel = 2'b00;
    bound_en = 1'b0;
    ok_trim = 66;
    write_fsel(2'b01);
    guard = 0;
    while (!fail_flag && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    check(fail_flag == 1'b1, "R7 fail flag", int'(fail_flag), 1);
    check(trim == 6'd63, "R5 high saturation", int'(trim), 63);
    check(freq_sel == 2'b00 && !locked, "R7 select cleared", int'(freq_sel), 0);
    check(err_flag == 1'b1, "R8 error flagged, loop kept stepping", int'(err_flag), 1);
    repeat (800) @(negedge clk);
    check(trim == 6'd63, "R7 trim frozen after fail", int'(trim), 63);

    // R10 / R9 interrupt gating and write-1 clears
    fail_ie = 1'b1;
    err_ie = 1'b0;
    @(negedge clk);
    check(irq == 1'b1, "R10 fail irq", int'(irq), 1);
    pulse_clear(1'b1, 1'b0);
    check(!fail_flag && err_flag, "R9 fail cleared only", int'({fail_flag, err_flag}), 1);
    check(irq == 1'b0, "R10 masked err", int'(irq), 0);
    err_ie = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R10 err irq", int'(irq), 1);
    pulse_clear(1'b0, 1'b1);
    check(!err_flag && !irq, "R9 err cleared", int'({err_flag, irq}), 0);

    // R5 low saturation
    do_reset();
    ok_trim = -3;
    write_fsel(2'b01);
    guard = 0;
    while (!fail_flag && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    check(trim == 6'd0, "R5 low saturation", int'(trim), 0);
    check(fail_flag == 1'b1, "R7 fail at low end", int'(fail_flag), 1);

    // R8 stop on gross error
    do_reset();
    stop_on_err = 1'b1;
    ok_trim = 20;
    write_fsel(2'b01);
    guard = 0;
    while (freq_sel != 2'b00 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(err_flag == 1'b1, "R8 err flag", int'(err_flag), 1);
    check(trim == 6'd32 && freq_sel == 2'b00, "R8 stop without step", int'(trim), 32);
    check(!fail_flag, "R8 no fail", int'(fail_flag), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule